// File: doc/BRIEF.md
# Multi-Context Thread Scheduler

This block decides which of up to eight hardware thread contexts owns an execution engine. Every context carries its own start address, a mask of signal events that have arrived and a mask of the events it waits for. Software reaches these per-context values indirectly: it first loads a pointer register with a context number, then reads or writes the three indirect registers, which act on the selected context only. A global enable register decides which contexts may move from ready to executing.

Instruction execution is not modelled. The engine reports instead that the running context has yielded or killed itself, and other logic delivers signal events into a context's signal mask. A context that is executing keeps the engine until it yields or is killed. After that, one idle cycle passes, and then a round-robin arbiter picks the next context that is both ready and enabled, starting its search just after the most recent owner. The start address of the running context is presented on an output for the fetch logic.

Top module: `ctx_sched`

## Requirements
- R1: After reset every context is inactive (state code 0), no context executes, the enable bits and pointer are 0, all masks and start addresses are 0, and the most recent owner is context 7 (the active status register reads 0x00000007).
- R2: Bits 2:0 of the pointer register (offset 0x020) select the context addressed by the indirect start address register (0x040), signal-mask register (0x048) and wakeup-mask register (0x050). Writes and reads of those registers touch only the selected context, and the pointer reads back.
- R3: A write to 0x040 loads bits 11:0 as the selected context's start address. If that context is inactive, it becomes sleeping (code 1) at the same edge. A read of 0x040 returns the start address in bits 11:0 and the state in bits 17:16 (0 inactive, 1 sleeping, 2 ready, 3 executing).
- R4: A sleeping context becomes ready at the next edge once (signal mask AND wakeup mask) is nonzero. An event input (valid, context number, bits) ORs its bits into that context's signal mask.
- R5: Bits 15:8 of the enable register (offset 0x018) gate contexts 0 to 7. A ready context is granted, and becomes executing at the next edge, only when its enable bit is set and no context is executing.
- R6: Clearing an enable bit never preempts the executing context. It keeps the engine until it yields or is killed.
- R7: A yield returns the executing context to sleeping, clears its signal mask (except for event bits that arrive in the same cycle) and leaves its wakeup mask unchanged.
- R8: A kill returns the executing context to inactive. Kill takes precedence over a simultaneous yield. An inactive context ignores events.
- R9: The grant goes to the first ready and enabled context in increasing order after the most recent owner, wrapping from 7 to 0.
- R10: In the cycle after a yield or kill, no context executes. A grant can make a context executing at the following edge at the earliest.
- R11: The active status register (offset 0x044) has bit 31 set while a context executes and holds in bits 2:0 the executing or most recent context. Busy, context and start-address outputs carry the same information.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| evt_valid | input | 1 | Signal event strobe |
| evt_ctx | input | 3 | Context receiving the event |
| evt_bits | input | 16 | Event bits ORed into the signal mask |
| exec_yield | input | 1 | Executing context yields |
| exec_kill | input | 1 | Executing context kills itself |
| exec_busy | output | 1 | A context is executing |
| exec_ctx | output | 3 | Executing or most recent context |
| exec_pc | output | 12 | Start address of exec_ctx |

## Verification
A corrupted context state would appear at the ports within one or two cycles. The wrong context would take the engine, the idle gap after a yield would go missing, or the indirect status read would give the wrong state code. A damaged round-robin pointer shows on exec_ctx at the first grant where more than one context is ready. A lost wakeup mask keeps a context from ever being granted again after its next event. The bench runs a cycle-accurate reference model alongside the design and compares busy, context and start address on every cycle. This catches a divergence in the cycle it first reaches the ports.

// File: rtl/ctx_sched_pkg.sv
package ctx_sched_pkg;
   typedef enum logic [1:0] {
      CS_IDLE  = 2'd0,
      CS_SLEEP = 2'd1,
      CS_READY = 2'd2,
      CS_RUN   = 2'd3
   } ctx_state_e;

   localparam int OFS_ENABLE = 'h018;
   localparam int OFS_PTR    = 'h020;
   localparam int OFS_STS    = 'h040;
   localparam int OFS_ACTIVE = 'h044;
   localparam int OFS_SIG    = 'h048;
   localparam int OFS_WAKE   = 'h050;
   localparam int ENABLE_LSB = 8;
   localparam int STATE_LSB  = 16;
   localparam int BUSY_BIT   = 31;
endpackage

// File: rtl/ctx_rr_arb.sv
module ctx_rr_arb #(
   parameter int N   = 8,
   parameter int IDW = 3
) (
   input  logic [N-1:0]   req,
   input  logic [IDW-1:0] last,
   output logic [IDW-1:0] pick,
   output logic           any
);
   function automatic int wrap_idx(input int base, input int step);
      int s;
      s = base + step;
      if (s >= N) s = s - N;
      return s;
   endfunction

   always_comb begin
      pick = last;
      any  = 1'b0;
      for (int i = N; i >= 1; i--) begin
         if (req[wrap_idx(int'(last), i)]) begin
            pick = IDW'(wrap_idx(int'(last), i));
            any  = 1'b1;
         end
      end
   end

   always_comb begin
      if (any) a_r9_pick_requests: assert (req[pick]);
   end
endmodule

// File: rtl/ctx_slot.sv
module ctx_slot
   import ctx_sched_pkg::*;
#(
   parameter int PC_W  = 12,
   parameter int SIG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_pc,
   input  logic             wr_sig,
   input  logic             wr_wake,
   input  logic [31:0]      wdata,
   input  logic [SIG_W-1:0] evt,
   input  logic             grant,
   input  logic             leave_yield,
   input  logic             leave_kill,
   output ctx_state_e       state_o,
   output logic [PC_W-1:0]  pc_o,
   output logic [SIG_W-1:0] sig_o,
   output logic [SIG_W-1:0] wake_o
);
   ctx_state_e       state_q;
   logic [PC_W-1:0]  pc_q;
   logic [SIG_W-1:0] sig_q, wake_q;
   logic             woken;

   assign woken = |(sig_q & wake_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= CS_IDLE;
         pc_q    <= '0;
         sig_q   <= '0;
         wake_q  <= '0;
      end else begin
         if (wr_wake) wake_q <= wdata[SIG_W-1:0];
         if (wr_pc)   pc_q   <= wdata[PC_W-1:0];
         if (leave_yield && !leave_kill) sig_q <= evt;
         else sig_q <= (wr_sig ? wdata[SIG_W-1:0] : sig_q) | evt;
         if (leave_kill)                         state_q <= CS_IDLE;
         else if (leave_yield)                   state_q <= CS_SLEEP;
         else if (grant)                         state_q <= CS_RUN;
         else if (state_q == CS_SLEEP && woken)  state_q <= CS_READY;
         else if (state_q == CS_IDLE && wr_pc)   state_q <= CS_SLEEP;
      end
   end

   assign state_o = state_q;
   assign pc_o    = pc_q;
   assign sig_o   = sig_q;
   assign wake_o  = wake_q;

   a_r8_kill_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      leave_kill |=> state_q == CS_IDLE);
   a_r7_wake_kept: assert property (@(posedge clk) disable iff (!rst_n)
      leave_yield && !leave_kill && !wr_wake |=> state_q == CS_SLEEP && $stable(wake_q));
   a_r5_grant_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> state_q == CS_READY);
endmodule

// File: rtl/ctx_sched.sv
module ctx_sched
   import ctx_sched_pkg::*;
#(
   parameter int NCTX   = 8,
   parameter int PC_W   = 12,
   parameter int SIG_W  = 16,
   parameter int ADDR_W = 9
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [31:0]           reg_wdata,
   output logic [31:0]           reg_rdata,
   input  logic                  evt_valid,
   input  logic [$clog2(NCTX)-1:0] evt_ctx,
   input  logic [SIG_W-1:0]      evt_bits,
   input  logic                  exec_yield,
   input  logic                  exec_kill,
   output logic                  exec_busy,
   output logic [$clog2(NCTX)-1:0] exec_ctx,
   output logic [PC_W-1:0]       exec_pc
);
   localparam int IDW = $clog2(NCTX);

   if (NCTX < 2 || NCTX > 8) begin : g_bad_nctx
      $error("ctx_sched: NCTX must be 2..8");
   end
   if (PC_W < 1 || PC_W > 16) begin : g_bad_pcw
      $error("ctx_sched: PC_W must be 1..16");
   end
   if (SIG_W < 1 || SIG_W > 32) begin : g_bad_sigw
      $error("ctx_sched: SIG_W must be 1..32");
   end
   if (ADDR_W < 7) begin : g_bad_addrw
      $error("ctx_sched: ADDR_W too small for register map");
   end

   logic [NCTX-1:0] en_q;
   logic [IDW-1:0]  ptr_q, id_q, pick;
   logic            busy_q, any;
   logic            hit_en, hit_ptr, hit_sts, hit_sig, hit_wake;

   ctx_state_e       st   [NCTX];
   logic [PC_W-1:0]  pcv  [NCTX];
   logic [SIG_W-1:0] sigv [NCTX];
   logic [SIG_W-1:0] wakev[NCTX];
   logic [NCTX-1:0]  req, grant, run_vec;

   assign hit_en   = reg_wr && reg_addr == ADDR_W'(OFS_ENABLE);
   assign hit_ptr  = reg_wr && reg_addr == ADDR_W'(OFS_PTR);
   assign hit_sts  = reg_wr && reg_addr == ADDR_W'(OFS_STS);
   assign hit_sig  = reg_wr && reg_addr == ADDR_W'(OFS_SIG);
   assign hit_wake = reg_wr && reg_addr == ADDR_W'(OFS_WAKE);

   for (genvar g = 0; g < NCTX; g++) begin : g_slot
      logic sel, mine;
      assign sel  = ptr_q == IDW'(g);
      assign mine = busy_q && id_q == IDW'(g);
      ctx_slot #(.PC_W(PC_W), .SIG_W(SIG_W)) slot_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_pc      (hit_sts && sel),
         .wr_sig     (hit_sig && sel),
         .wr_wake    (hit_wake && sel),
         .wdata      (reg_wdata),
         .evt        ((evt_valid && evt_ctx == IDW'(g)) ? evt_bits : '0),
         .grant      (grant[g]),
         .leave_yield(mine && exec_yield),
         .leave_kill (mine && exec_kill),
         .state_o    (st[g]),
         .pc_o       (pcv[g]),
         .sig_o      (sigv[g]),
         .wake_o     (wakev[g])
      );
      assign req[g]     = st[g] == CS_READY && en_q[g];
      assign grant[g]   = !busy_q && any && pick == IDW'(g);
      assign run_vec[g] = st[g] == CS_RUN;
   end

   ctx_rr_arb #(.N(NCTX), .IDW(IDW)) arb_i (
      .req (req),
      .last(id_q),
      .pick(pick),
      .any (any)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= '0;
         ptr_q  <= '0;
         busy_q <= 1'b0;
         id_q   <= IDW'(NCTX - 1);
      end else begin
         if (hit_en)  en_q  <= reg_wdata[ENABLE_LSB +: NCTX];
         if (hit_ptr) ptr_q <= reg_wdata[IDW-1:0];
         if (!busy_q && any) begin
            busy_q <= 1'b1;
            id_q   <= pick;
         end else if (busy_q && (exec_yield || exec_kill)) begin
            busy_q <= 1'b0;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (int'(reg_addr))
         OFS_ENABLE: reg_rdata[ENABLE_LSB +: NCTX] = en_q;
         OFS_PTR:    reg_rdata[IDW-1:0] = ptr_q;
         OFS_STS: begin
            reg_rdata[PC_W-1:0]          = pcv[ptr_q];
            reg_rdata[STATE_LSB +: 2]    = st[ptr_q];
         end
         OFS_ACTIVE: begin
            reg_rdata[BUSY_BIT]  = busy_q;
            reg_rdata[IDW-1:0]   = id_q;
         end
         OFS_SIG:  reg_rdata[SIG_W-1:0] = sigv[ptr_q];
         OFS_WAKE: reg_rdata[SIG_W-1:0] = wakev[ptr_q];
         default:  reg_rdata = '0;
      endcase
   end

   assign exec_busy = busy_q;
   assign exec_ctx  = id_q;
   assign exec_pc   = pcv[id_q];

   a_r6_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !exec_yield && !exec_kill |=> busy_q && $stable(id_q));
   a_r10_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && (exec_yield || exec_kill) |=> !busy_q);
   a_r5_enabled_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> (($past(en_q) >> id_q) & NCTX'(1)) != '0);
   a_r11_one_runner: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(run_vec) == (busy_q ? 1 : 0));
   a_r11_runner_matches: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> run_vec[id_q]);
endmodule

// File: tb/ctx_sched_tb_top.sv
module ctx_sched_tb_top;
   localparam int A_EN = 'h018, A_PTR = 'h020, A_STS = 'h040;
   localparam int A_ACT = 'h044, A_SIG = 'h048, A_WAKE = 'h050;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [8:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        evt_valid = 1'b0;
   logic [2:0]  evt_ctx = '0;
   logic [15:0] evt_bits = '0;
   logic        exec_yield = 1'b0;
   logic        exec_kill = 1'b0;
   logic        exec_busy;
   logic [2:0]  exec_ctx;
   logic [11:0] exec_pc;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ctx_sched dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_valid(evt_valid),
      .evt_ctx(evt_ctx), .evt_bits(evt_bits), .exec_yield(exec_yield),
      .exec_kill(exec_kill), .exec_busy(exec_busy), .exec_ctx(exec_ctx),
      .exec_pc(exec_pc)
   );

   // reference model
   int          m_st[8];
   logic [11:0] m_pc[8];
   logic [15:0] m_sig[8], m_wake[8];
   logic [7:0]  m_en;
   int          m_ptr, m_id;
   bit          m_busy;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < 8; c++) begin
            m_st[c] = 0; m_pc[c] = '0; m_sig[c] = '0; m_wake[c] = '0;
         end
         m_en = '0; m_ptr = 0; m_id = 7; m_busy = 0;
      end else begin
         int pick; bit any;
         pick = -1; any = 0;
         if (!m_busy)
            for (int i = 1; i <= 8; i++)
               if (!any && m_st[(m_id + i) % 8] == 2 && m_en[(m_id + i) % 8]) begin
                  pick = (m_id + i) % 8; any = 1;
               end
         for (int c = 0; c < 8; c++) begin
            bit sel, hit, wpc, wsig, wwake;
            logic [15:0] ev;
            sel   = (m_ptr == c);
            wpc   = reg_wr && reg_addr == 9'(A_STS) && sel;
            wsig  = reg_wr && reg_addr == 9'(A_SIG) && sel;
            wwake = reg_wr && reg_addr == 9'(A_WAKE) && sel;
            hit   = m_busy && m_id == c;
            ev    = (evt_valid && evt_ctx == 3'(c)) ? evt_bits : 16'h0;
            if (hit && exec_kill) m_st[c] = 0;
            else if (hit && exec_yield) m_st[c] = 1;
            else if (pick == c) m_st[c] = 3;
            else if (m_st[c] == 1 && (m_sig[c] & m_wake[c]) != 0) m_st[c] = 2;
            else if (m_st[c] == 0 && wpc) m_st[c] = 1;
            if (hit && exec_yield && !exec_kill) m_sig[c] = ev;
            else m_sig[c] = (wsig ? reg_wdata[15:0] : m_sig[c]) | ev;
            if (wwake) m_wake[c] = reg_wdata[15:0];
            if (wpc) m_pc[c] = reg_wdata[11:0];
         end
         if (any) begin m_busy = 1; m_id = pick; end
         else if (m_busy && (exec_yield || exec_kill)) m_busy = 0;
         if (reg_wr && reg_addr == 9'(A_EN)) m_en = reg_wdata[15:8];
         if (reg_wr && reg_addr == 9'(A_PTR)) m_ptr = int'(reg_wdata[2:0]);
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] got,
                      input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   // continuous comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R11", "busy vs model", 32'(exec_busy), 32'(m_busy));
         chk("R9", "context vs model", 32'(exec_ctx), 32'(m_id));
         chk("R11", "pc vs model", 32'(exec_pc), 32'(m_pc[m_id]));
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = 9'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      reg_addr = 9'(a);
      #1 d = reg_rdata;
   endtask

   task automatic yield_pulse(input bit k);
      exec_yield = 1'b1; exec_kill = k;
      @(negedge clk);
      exec_yield = 1'b0; exec_kill = 1'b0;
   endtask

   task automatic evt_pulse(input int c, input logic [15:0] b);
      evt_valid = 1'b1; evt_ctx = 3'(c); evt_bits = b;
      @(negedge clk);
      evt_valid = 1'b0;
   endtask

   task automatic arm(input int c, input logic [11:0] pc);
      wr(A_PTR, 32'(c)); wr(A_SIG, 1); wr(A_WAKE, 1); wr(A_STS, 32'(pc));
   endtask

   initial begin
      logic [31:0] v;
      void'($urandom(32'd2024));
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1
      chk("R1", "busy after reset", 32'(exec_busy), 0);
      rd(A_ACT, v);  chk("R1", "active status", v, 32'h7);
      rd(A_EN, v);   chk("R1", "enables", v, 0);
      rd(A_STS, v);  chk("R1", "ctx0 status", v, 0);
      // R3 / R4 / R5
      arm(0, 12'h123);
      rd(A_STS, v);  chk("R3", "sleeping after pc write", v, 32'h0001_0123);
      step(1);
      rd(A_STS, v);  chk("R4", "ready after masks match", v, 32'h0002_0123);
      step(2);
      chk("R5", "not granted while disabled", 32'(exec_busy), 0);
      wr(A_EN, 32'h0000_0100);
      step(1);
      chk("R5", "granted when enabled", {exec_busy, exec_ctx, exec_pc}, {1'b1, 3'd0, 12'h123});
      rd(A_ACT, v);  chk("R11", "active status busy", v, 32'h8000_0000);
      rd(A_STS, v);  chk("R3", "executing state code", v, 32'h0003_0123);
      // R6
      wr(A_EN, 0);
      step(3);
      chk("R6", "still running after disable", {exec_busy, exec_ctx}, {1'b1, 3'd0});
      // R7 / R10
      yield_pulse(0);
      chk("R10", "idle after yield", 32'(exec_busy), 0);
      rd(A_WAKE, v); chk("R7", "wake kept", v, 1);
      rd(A_SIG, v);  chk("R7", "sig cleared", v, 0);
      rd(A_STS, v);  chk("R7", "sleeping after yield", v, 32'h0001_0123);
      // R9 round robin
      arm(2, 12'h202); arm(3, 12'h203); arm(1, 12'h201);
      step(2);
      wr(A_EN, 32'h0000_FF00);
      step(1);
      chk("R9", "first after ctx0", {exec_busy, exec_ctx, exec_pc}, {1'b1, 3'd1, 12'h201});
      yield_pulse(0);
      chk("R10", "gap before ctx2", 32'(exec_busy), 0);
      step(1);
      chk("R9", "next is ctx2", {exec_busy, exec_ctx}, {1'b1, 3'd2});
      yield_pulse(0);
      step(1);
      chk("R9", "next is ctx3", {exec_busy, exec_ctx}, {1'b1, 3'd3});
      yield_pulse(0);
      step(2);
      chk("R7", "all asleep", 32'(exec_busy), 0);
      wr(A_EN, 0);
      evt_pulse(0, 16'h1);
      evt_pulse(2, 16'h1);
      step(3);
      wr(A_EN, 32'h0000_FF00);
      step(1);
      chk("R9", "wrap to ctx0", {exec_busy, exec_ctx}, {1'b1, 3'd0});
      yield_pulse(0);
      step(1);
      chk("R9", "then ctx2", {exec_busy, exec_ctx, exec_pc}, {1'b1, 3'd2, 12'h202});
      // R8
      yield_pulse(1);
      chk("R8", "idle after kill", 32'(exec_busy), 0);
      wr(A_PTR, 2);
      rd(A_STS, v);  chk("R8", "killed ctx inactive", v, 32'h0000_0202);
      evt_pulse(2, 16'h1);
      step(3);
      chk("R8", "inactive ignores event", 32'(exec_busy), 0);
      rd(A_STS, v);  chk("R8", "still inactive", v, 32'h0000_0202);
      // R2
      wr(A_PTR, 5); wr(A_SIG, 32'h0000_ABCD); wr(A_WAKE, 0);
      rd(A_PTR, v);  chk("R2", "pointer readback", v, 5);
      rd(A_SIG, v);  chk("R2", "ctx5 sig", v, 32'h0000_ABCD);
      wr(A_PTR, 3);
      rd(A_SIG, v);  chk("R2", "ctx3 sig untouched", v, 0);
      // random phase against the model
      for (int n = 0; n < 4000; n++) begin
         int r;
         exec_yield = ($urandom % 100) < 25;
         exec_kill  = ($urandom % 100) < 4;
         evt_valid  = ($urandom % 100) < 40;
         evt_ctx    = 3'($urandom % 8);
         evt_bits   = 16'(1) << ($urandom % 4);
         reg_wr     = ($urandom % 100) < 15;
         r = $urandom % 5;
         case (r)
            0: reg_addr = 9'(A_EN);
            1: reg_addr = 9'(A_PTR);
            2: reg_addr = 9'(A_SIG);
            3: reg_addr = 9'(A_WAKE);
            default: reg_addr = 9'(A_STS);
         endcase
         reg_wdata = (r == 2 || r == 3) ? ($urandom & 32'hF) : $urandom;
         @(negedge clk);
      end
      reg_wr = 0; exec_yield = 0; exec_kill = 0; evt_valid = 0;
      step(2);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule